// File: doc/BRIEF.md
# Infrared Receive Code FIFO with Interrupt Flags

This block sits between an infrared pulse sampler and the processor. The sampler hands it one 8-bit run-length code at a time with a valid strobe, and pulses a separate strobe when a packet ends. Codes wait in a first-in first-out store of 16 or 64 entries, set by a parameter, until software reads them one at a time through a small register port. Each read of the data register removes the oldest entry.

Three sticky flags record events: the store overflowed, a packet ended, and the fill count rose above a level that software sets. Each flag has an enable bit at the same bit position in the enable register. The single interrupt line is asserted when any flag and its enable are both set. Software clears a flag by writing 1 to its bit. The status word also carries the live fill count, so one read tells the handler how many codes it can drain.

Register select (`reg_addr_i`): 0 is the code data register (read pops, write ignored), 1 is the interrupt enable register, 2 is the status register. Read data appears on `reg_rdata_o` one clock after the read strobe.

Top module: `ir_code_rx`

## Requirements
- R1: A read of register 0 returns the oldest stored code in bits [7:0], with the upper bits zero, and removes that entry. Codes come out in the order they were accepted.
- R2: The enable register (register 1) holds the overflow enable at bit 0, the packet-end enable at bit 1, the data-available enable at bit 4, and the trigger level in a field of CNT_W bits starting at bit 8. Reading it returns the value last written in those fields and zero elsewhere.
- R3: A code offered while the store holds DEPTH entries, with no pop in the same cycle, is dropped. The count stays at DEPTH and status bit 0 (overflow) is set.
- R4: A packet-end strobe sets status bit 1 at the next clock edge.
- R5: Status bit 4 (data available) is set at the clock edge after any cycle in which the fill count is greater than the trigger level.
- R6: Status (register 2) reports the fill count in a CNT_W-bit field starting at bit 8, wide enough to hold DEPTH. `fill_o` carries the same count.
- R7: Writing register 2 clears each flag whose bit (0, 1 or 4) is 1 in the write data, so 0xFF clears all three. Flags written with 0 are left as they are. If a flag's set condition is present in the same cycle as its clear, the set wins.
- R8: `irq_o` is high exactly when some status flag and the enable bit at the same position are both 1.
- R9: A pop of an empty store returns 0x00 and leaves the count at zero.
- R10: A code accepted in the same cycle as a pop of a non-empty store leaves the count unchanged.
- R11: After reset the count, all flags, the enable register and `irq_o` are zero. The store accepts exactly DEPTH codes (16 or 64) before it reports full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| code_valid_i | input | 1 | A code is offered this cycle |
| code_i | input | 8 | Run-length code from the sampler |
| pkt_end_i | input | 1 | Packet-end strobe from the sampler |
| reg_addr_i | input | 2 | Register select |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, valid the cycle after a read |
| fill_o | output | CNT_W | Live entry count |
| irq_o | output | 1 | Interrupt request |

## Verification
A bad pointer or count shows up at the ports right away. Codes come out of order or duplicated on the next data read, or `fill_o` drifts from the number of pushes minus pops within one cycle of the faulty update. A flag that fails to set or to clear is visible on `irq_o` one cycle after the event or the write, once its enable is on, and also on the next status read. The order of the drain after an overflow shows whether the dropped code overwrote a stored one.

// File: rtl/ir_code_pkg.sv
package ir_code_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned CODE_W = 8;

  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_IEN  = 2'd1,
    SEL_STAT = 2'd2
  } reg_sel_e;

  // bit positions shared by enable and status words
  localparam int unsigned BIT_OV   = 0;
  localparam int unsigned BIT_PE   = 1;
  localparam int unsigned BIT_DA   = 4;
  localparam int unsigned FLD_LSB  = 8;

  typedef struct packed {
    logic da;
    logic pe;
    logic ov;
  } flags_t;
endpackage

// File: rtl/ir_code_store.sv
module ir_code_store #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned W      = 8,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [W-1:0]     din_i,
  input  logic             pop_i,
  output logic [W-1:0]     dout_o,
  output logic [CNT_W-1:0] count_o,
  output logic             drop_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             full, empty, pop_ok, push_ok;

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign pop_ok  = pop_i && !empty;
  // a pop in the same cycle frees a slot for the incoming code
  assign push_ok = push_i && (!full || pop_ok);
  assign drop_o  = push_i && !push_ok;
  assign dout_o  = empty ? '0 : mem_q[rd_ptr_q];
  assign count_o = cnt_q;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    if (p == PTR_W'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_ok) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_ok)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_ptr_q] <= din_i;
  end
endmodule

// File: rtl/ir_rx_flags.sv
module ir_rx_flags
  import ir_code_pkg::*;
#(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ov_set_i,
  input  logic             pe_set_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] level_i,
  input  flags_t           clr_i,
  output flags_t           flags_o
);
  flags_t set, flags_q;

  assign set.ov = ov_set_i;
  assign set.pe = pe_set_i;
  assign set.da = (count_i > level_i);

  // set dominates a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= set | (flags_q & ~clr_i);
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/ir_rx_regs.sv
module ir_rx_regs
  import ir_code_pkg::*;
#(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       addr_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [REG_W-1:0] wdata_i,
  input  flags_t           flags_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [CODE_W-1:0] code_i,
  output flags_t           en_o,
  output logic [CNT_W-1:0] level_o,
  output logic             pop_o,
  output flags_t           clr_o,
  output logic [REG_W-1:0] rdata_o
);
  flags_t           en_q;
  logic [CNT_W-1:0] lvl_q;
  logic [REG_W-1:0] rdata_q, rd_mux;
  reg_sel_e         sel;

  assign sel   = reg_sel_e'(addr_i);
  assign pop_o = rd_i && (sel == SEL_DATA);

  always_comb begin
    clr_o = '0;
    if (wr_i && sel == SEL_STAT) begin
      clr_o.ov = wdata_i[BIT_OV];
      clr_o.pe = wdata_i[BIT_PE];
      clr_o.da = wdata_i[BIT_DA];
    end
  end

  function automatic logic [REG_W-1:0] pack_word(input flags_t f,
                                                  input logic [CNT_W-1:0] fld);
    logic [REG_W-1:0] w;
    w = '0;
    w[BIT_OV] = f.ov;
    w[BIT_PE] = f.pe;
    w[BIT_DA] = f.da;
    w[FLD_LSB +: CNT_W] = fld;
    return w;
  endfunction

  always_comb begin
    unique case (sel)
      SEL_DATA: rd_mux = REG_W'(code_i);
      SEL_IEN:  rd_mux = pack_word(en_q, lvl_q);
      SEL_STAT: rd_mux = pack_word(flags_i, count_i);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= '0;
      lvl_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (wr_i && sel == SEL_IEN) begin
        en_q.ov <= wdata_i[BIT_OV];
        en_q.pe <= wdata_i[BIT_PE];
        en_q.da <= wdata_i[BIT_DA];
        lvl_q   <= wdata_i[FLD_LSB +: CNT_W];
      end
      if (rd_i) rdata_q <= rd_mux;
    end
  end

  assign en_o    = en_q;
  assign level_o = lvl_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/ir_code_rx.sv
module ir_code_rx
  import ir_code_pkg::*;
#(
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              code_valid_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              pkt_end_i,
  input  logic [1:0]        reg_addr_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic [CNT_W-1:0]  fill_o,
  output logic              irq_o
);
  logic [CODE_W-1:0] head;
  logic [CNT_W-1:0]  count, level;
  logic              pop, drop;
  flags_t            flags, en, clr;

  generate
    if (DEPTH != 16 && DEPTH != 64) begin : g_bad_depth
      initial $error("ir_code_rx: DEPTH must be 16 or 64");
    end
  endgenerate

  ir_code_store #(.DEPTH(DEPTH), .W(CODE_W)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (code_valid_i),
    .din_i   (code_i),
    .pop_i   (pop),
    .dout_o  (head),
    .count_o (count),
    .drop_o  (drop)
  );

  ir_rx_flags #(.CNT_W(CNT_W)) u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ov_set_i (drop),
    .pe_set_i (pkt_end_i),
    .count_i  (count),
    .level_i  (level),
    .clr_i    (clr),
    .flags_o  (flags)
  );

  ir_rx_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (reg_addr_i),
    .wr_i    (reg_wr_i),
    .rd_i    (reg_rd_i),
    .wdata_i (reg_wdata_i),
    .flags_i (flags),
    .count_i (count),
    .code_i  (head),
    .en_o    (en),
    .level_o (level),
    .pop_o   (pop),
    .clr_o   (clr),
    .rdata_o (reg_rdata_o)
  );

  assign fill_o = count;
  assign irq_o  = |(flags & en);
endmodule

// File: rtl/ir_code_rx_chk.sv
module ir_code_rx_chk #(
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             code_valid_i,
  input logic             pkt_end_i,
  input logic [1:0]       reg_addr_i,
  input logic             reg_rd_i,
  input logic [31:0]      reg_rdata_o,
  input logic [CNT_W-1:0] fill_o,
  input logic             irq_o,
  input logic [2:0]       flg,
  input logic [2:0]       ena,
  input logic [CNT_W-1:0] lvl
);
  logic pop_req;
  assign pop_req = reg_rd_i && (reg_addr_i == 2'd0);

  p_fill_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_o <= CNT_W'(DEPTH));

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_valid_i && fill_o == CNT_W'(DEPTH) && !pop_req
    |=> flg[0] && fill_o == CNT_W'(DEPTH));

  p_push_pop_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_valid_i && pop_req && fill_o != '0 |=> $stable(fill_o));

  p_empty_pop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_req && !code_valid_i && fill_o == '0
    |=> fill_o == '0 && reg_rdata_o[7:0] == 8'h00);

  p_pkt_end_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_end_i |=> flg[1]);

  p_avail_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_o > lvl |=> flg[2]);

  p_irq_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flg[1] && ena[1]) |-> irq_o);

  p_irq_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ena == 3'b000 |-> !irq_o);
endmodule

bind ir_code_rx ir_code_rx_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .code_valid_i (code_valid_i),
  .pkt_end_i    (pkt_end_i),
  .reg_addr_i   (reg_addr_i),
  .reg_rd_i     (reg_rd_i),
  .reg_rdata_o  (reg_rdata_o),
  .fill_o       (fill_o),
  .irq_o        (irq_o),
  .flg          (flags),
  .ena          (en),
  .lvl          (level)
);

// File: tb/tb_ir_code_rx.sv
module tb_ir_code_rx;
  localparam int unsigned DEPTH  = 16;
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1);
  localparam time         CLK_PERIOD = 10ns;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             code_valid = 1'b0;
  logic [7:0]       code = '0;
  logic             pkt_end = 1'b0;
  logic [1:0]       addr = '0;
  logic             wr = 1'b0, rd = 1'b0;
  logic [31:0]      wdata = '0;
  logic [31:0]      rdata;
  logic [CNT_W-1:0] fill;
  logic             irq;

  int unsigned n_checks = 0, n_errors = 0;
  logic [7:0]  exp_q[$];
  logic        mon_hit = 1'b0;
  logic [31:0] got;

  always #(CLK_PERIOD/2) clk = ~clk;

  ir_code_rx #(.DEPTH(DEPTH)) dut (
    .clk_i(clk), .rst_ni(rst_n), .code_valid_i(code_valid), .code_i(code),
    .pkt_end_i(pkt_end), .reg_addr_i(addr), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .fill_o(fill), .irq_o(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // monitor: compare each data-register read against the scoreboard (R1, R9)
  always @(posedge clk) mon_hit <= rd && addr == 2'd0;
  always @(negedge clk) begin
    if (mon_hit) begin
      logic [7:0] e;
      e = (exp_q.size() != 0) ? exp_q.pop_front() : 8'h00;
      check(e == 8'h00 ? "R9 empty pop" : "R1 code order", rdata, {24'h0, e});
    end
  end

  // all tasks start and end at a falling edge
  task automatic tick();
    @(negedge clk);
  endtask

  task automatic push(logic [7:0] b, int unsigned cur);
    code_valid = 1'b1; code = b;
    if (cur < DEPTH) exp_q.push_back(b);
    tick();
    code_valid = 1'b0;
  endtask

  task automatic push_pop(logic [7:0] b);
    code_valid = 1'b1; code = b; rd = 1'b1; addr = 2'd0;
    exp_q.push_back(b);
    tick();
    code_valid = 1'b0; rd = 1'b0;
  endtask

  task automatic pop();
    rd = 1'b1; addr = 2'd0;
    tick();
    rd = 1'b0;
  endtask

  task automatic reg_wr(logic [1:0] a, logic [31:0] d);
    wr = 1'b1; addr = a; wdata = d;
    tick();
    wr = 1'b0;
  endtask

  task automatic reg_rd(logic [1:0] a, output logic [31:0] d);
    rd = 1'b1; addr = a;
    tick();
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual=running expected=done");
    finish_run();
  end

  initial begin
    tick(); tick();
    rst_n = 1'b1;
    tick();
    // R11 reset state
    check("R11 reset fill", 32'(fill), 0);
    check("R11 reset irq", 32'(irq), 0);
    reg_rd(2'd2, got); check("R11 reset status", got, 0);
    reg_rd(2'd1, got); check("R11 reset enable", got, 0);

    // R6 count and R5 data-available at level 0
    for (int i = 0; i < 5; i++) push(8'hA0 + 8'(i), i);
    tick();
    check("R6 fill_o", 32'(fill), 5);
    reg_rd(2'd2, got); check("R6 R5 status count and avail", got, (5 << 8) | 32'h10);

    for (int i = 0; i < 3; i++) pop();
    tick();
    check("R6 fill after pops", 32'(fill), 2);

    // R7 clear-all while count is below the new level
    reg_wr(2'd1, 32'(7) << 8);
    reg_wr(2'd2, 32'hFF);
    tick();
    reg_rd(2'd2, got); check("R7 clear all", got, 2 << 8);

    // R5 above level, R8 gated by enable, R2 readback
    for (int i = 0; i < 6; i++) push(8'hB0 + 8'(i), 2 + i);
    tick();
    reg_rd(2'd2, got); check("R5 avail above level", got, (8 << 8) | 32'h10);
    check("R8 irq masked", 32'(irq), 0);
    reg_wr(2'd1, (32'(7) << 8) | 32'h10);
    check("R8 irq enabled", 32'(irq), 1);
    reg_rd(2'd1, got); check("R2 enable readback", got, (32'(7) << 8) | 32'h10);
    reg_wr(2'd1, 32'hFFFF_FFFF);
    reg_rd(2'd1, got); check("R2 unused bits zero", got, (32'((1 << CNT_W) - 1) << 8) | 32'h13);
    reg_wr(2'd1, 32'(7) << 8);

    // R10 push and pop together
    push_pop(8'hC0);
    push_pop(8'hC1);
    tick();
    check("R10 fill held", 32'(fill), 8);

    // R11 full at DEPTH, R3 drop on full
    for (int i = 8; i < DEPTH; i++) push(8'hD0 + 8'(i), i);
    tick();
    check("R11 full count", 32'(fill), DEPTH);
    push(8'hEE, DEPTH);
    tick();
    check("R3 fill stays full", 32'(fill), DEPTH);
    reg_rd(2'd2, got); check("R3 overflow flag", got, (DEPTH << 8) | 32'h11);

    // R1 drain order (dropped code must not appear)
    for (int i = 0; i < DEPTH; i++) pop();
    tick();
    check("R1 drained", 32'(fill), 0);
    pop();
    tick();
    check("R9 count stays zero", 32'(fill), 0);

    // R7 selective clear
    reg_rd(2'd2, got); check("R7 flags sticky", got, 32'h11);
    reg_wr(2'd2, 32'h10);
    reg_rd(2'd2, got); check("R7 clear one bit", got, 32'h01);
    reg_wr(2'd1, 32'h01);
    check("R8 irq overflow", 32'(irq), 1);
    reg_wr(2'd2, 32'hFF);
    check("R8 irq after clear", 32'(irq), 0);

    // R4 packet end
    pkt_end = 1'b1; tick(); pkt_end = 1'b0;
    reg_rd(2'd2, got); check("R4 packet end flag", got, 32'h02);
    reg_wr(2'd1, 32'h02);
    check("R8 irq packet end", 32'(irq), 1);
    // R7 set beats clear
    pkt_end = 1'b1;
    reg_wr(2'd2, 32'h02);
    pkt_end = 1'b0;
    reg_rd(2'd2, got); check("R7 set wins", got, 32'h02);
    reg_wr(2'd2, 32'h02);
    check("R7 pe cleared irq", 32'(irq), 0);
    reg_rd(2'd2, got); check("R7 pe cleared", got, 0);

    // data register write is ignored
    reg_wr(2'd0, 32'h55);
    tick();
    check("R1 data write ignored", 32'(fill), 0);

    tick();
    finish_run();
  end
endmodule